// File: doc/BRIEF.md
# DMA Channel Command/State Controller

This block holds the control/status word of one DMA channel. Software writes an 8-bit command into one byte of the word. It reads the channel's current 8-bit state from a neighbouring byte. The controller steps through a small set of states: off, idle, busy, held, halted, fault and clearing. A fetch-permit output tells the transfer engine whether it may start new work.

While the channel is enabled, the controller follows the engine's work-pending input. It reports busy when work is queued and idle otherwise. Three other inputs act on the channel directly. An engine error pulse drives it into fault. A manager stop input parks it in a halted state that software cannot enter by itself. A clear command starts a timed quiesce. The quiesce lasts a fixed, parameterised number of cycles and then leaves the channel off.

Top module: `chan_ctl`

## Requirements
- R1: After reset the read word is all zero. This means state off (0), command echo 0 and fetch_ok low.
- R2: In the read word, bits 15:8 hold the state and bits 23:16 echo the last legal command written while the state was not clearing. All other bits read zero. The state codes are off=0, idle=1, busy=2, held=3, halted=4, fault=5 and clearing=9. The command codes are off=0, enable=1, hold=2 and clear=9. Any other command code is ignored.
- R3: An enable command from off, held or halted moves the state to busy if work_pend is high at that edge, and to idle otherwise. While idle or busy, the state is re-evaluated each cycle from work_pend.
- R4: A hold command moves idle or busy to held, and new fetches stop. A hold command in held or halted changes nothing.
- R5: fetch_ok is high exactly when the state is idle or busy.
- R6: mgr_stop moves idle, busy or held to halted. mgr_stop has no effect in off, fault or clearing.
- R7: An off command moves idle, busy, held or halted to off.
- R8: eng_err moves idle, busy, held or halted to fault. eng_err is ignored in off.
- R9: Only a clear command leaves fault. Enable, off, hold and mgr_stop leave the state at fault.
- R10: A clear command from any state other than clearing shows clearing for exactly RST_CYCLES cycles and then shows off.
- R11: While clearing, writes, eng_err and mgr_stop have no effect, and this includes the command echo.
- R12: When several inputs arrive at the same edge, they are ranked as follows. A clear command ranks first, eng_err second, mgr_stop third, and any other command last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Write data; the command sits in bits 23:16 |
| work_pend | input | 1 | Engine has queued work |
| eng_err | input | 1 | Engine error pulse |
| mgr_stop | input | 1 | External manager stop request |
| csr_rdata | output | 32 | Read word: command echo 23:16, state 15:8 |
| fetch_ok | output | 1 | Engine may fetch new work |

## Verification
A table walks the channel along a path that takes each command through each stable state. Along that path, work_pend is toggled so that the busy/idle tracking can be told apart from a stuck state. Repeated hold commands, and stop or error arriving in states that must ignore them, separate real transitions from the cases that should have no effect. Directed runs write enable on every cycle of a clear. They count the clearing cycles against RST_CYCLES. They also apply clear, error, stop and commands together, which exposes a wrong priority order.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;

    localparam int FIELD_W = 8;
    localparam int CMD_LSB = 16;
    localparam int ST_LSB  = 8;

    typedef enum logic [FIELD_W-1:0] {
        ST_OFF   = 8'd0,
        ST_IDLE  = 8'd1,
        ST_BUSY  = 8'd2,
        ST_HELD  = 8'd3,
        ST_HALT  = 8'd4,
        ST_FAULT = 8'd5,
        ST_CLEAR = 8'd9
    } chan_st_e;

    typedef enum logic [FIELD_W-1:0] {
        CMD_OFF   = 8'd0,
        CMD_ON    = 8'd1,
        CMD_HOLD  = 8'd2,
        CMD_CLEAR = 8'd9
    } chan_cmd_e;

    typedef struct packed {
        logic               legal;
        logic               off;
        logic               on;
        logic               hold;
        logic               clear;
        logic [FIELD_W-1:0] code;
    } cmd_hits_t;

    typedef struct packed {
        chan_st_e           st;
        logic [FIELD_W-1:0] cmd;
    } fsm_regs_t;

endpackage

// File: rtl/chan_cmd_dec.sv
module chan_cmd_dec
    import chan_ctl_pkg::*;
(
    input  logic               wr,
    input  logic [FIELD_W-1:0] cmd_byte,
    output cmd_hits_t          hits
);
    always_comb begin
        hits       = '0;
        hits.code  = cmd_byte;
        hits.off   = wr && (cmd_byte == CMD_OFF);
        hits.on    = wr && (cmd_byte == CMD_ON);
        hits.hold  = wr && (cmd_byte == CMD_HOLD);
        hits.clear = wr && (cmd_byte == CMD_CLEAR);
        hits.legal = hits.off | hits.on | hits.hold | hits.clear;
    end
endmodule

// File: rtl/chan_quiesce_tmr.sv
module chan_quiesce_tmr #(
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = (RST_CYCLES < 2) ? 1 : $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(RST_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = LOAD_VAL;
        else if (run && (cnt_q != '0))
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/chan_state_fsm.sv
module chan_state_fsm
    import chan_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  cmd_hits_t          hits,
    input  logic               work_pend,
    input  logic               eng_err,
    input  logic               mgr_stop,
    input  logic               quiesce_done,
    output logic               tmr_load,
    output chan_st_e           state,
    output logic [FIELD_W-1:0] cmd_echo
);
    fsm_regs_t r_d, r_q;
    chan_st_e  work_st;
    logic      active;

    always_comb begin
        work_st  = work_pend ? ST_BUSY : ST_IDLE;
        active   = (r_q.st == ST_IDLE) || (r_q.st == ST_BUSY) ||
                   (r_q.st == ST_HELD) || (r_q.st == ST_HALT);
        r_d      = r_q;
        tmr_load = 1'b0;
        if (r_q.st == ST_CLEAR) begin
            if (quiesce_done) r_d.st = ST_OFF;
        end else begin
            if (hits.legal) r_d.cmd = hits.code;
            if (hits.clear) begin
                r_d.st   = ST_CLEAR;
                tmr_load = 1'b1;
            end else if (eng_err && active) begin
                r_d.st = ST_FAULT;
            end else if (mgr_stop && (r_q.st == ST_IDLE || r_q.st == ST_BUSY ||
                                      r_q.st == ST_HELD)) begin
                r_d.st = ST_HALT;
            end else begin
                case (r_q.st)
                    ST_OFF: if (hits.on) r_d.st = work_st;
                    ST_IDLE, ST_BUSY: begin
                        if (hits.off)       r_d.st = ST_OFF;
                        else if (hits.hold) r_d.st = ST_HELD;
                        else                r_d.st = work_st;
                    end
                    ST_HELD, ST_HALT: begin
                        if (hits.off)     r_d.st = ST_OFF;
                        else if (hits.on) r_d.st = work_st;
                    end
                    default: r_d.st = r_q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ST_OFF;
            r_q.cmd <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state    = r_q.st;
    assign cmd_echo = r_q.cmd;
endmodule

// File: rtl/chan_ctl.sv
module chan_ctl
    import chan_ctl_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic [31:0] csr_wdata,
    input  logic        work_pend,
    input  logic        eng_err,
    input  logic        mgr_stop,
    output logic [31:0] csr_rdata,
    output logic        fetch_ok
);
    cmd_hits_t          hits;
    chan_st_e           state;
    logic [FIELD_W-1:0] cmd_echo;
    logic               tmr_load;
    logic               quiesce_done;
    logic               unused_wbits;

    assign unused_wbits = ^{csr_wdata[31:CMD_LSB+FIELD_W], csr_wdata[CMD_LSB-1:0]};

    chan_cmd_dec u_dec (
        .wr       (csr_wr),
        .cmd_byte (csr_wdata[CMD_LSB +: FIELD_W]),
        .hits     (hits)
    );

    chan_quiesce_tmr #(.RST_CYCLES(RST_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .run   (state == ST_CLEAR),
        .done  (quiesce_done)
    );

    chan_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hits         (hits),
        .work_pend    (work_pend),
        .eng_err      (eng_err),
        .mgr_stop     (mgr_stop),
        .quiesce_done (quiesce_done),
        .tmr_load     (tmr_load),
        .state        (state),
        .cmd_echo     (cmd_echo)
    );

    always_comb begin
        csr_rdata                        = '0;
        csr_rdata[CMD_LSB +: FIELD_W]    = cmd_echo;
        csr_rdata[ST_LSB +: FIELD_W]     = state;
    end

    assign fetch_ok = (state == ST_IDLE) || (state == ST_BUSY);
endmodule

// File: rtl/chan_ctl_chk.sv
module chan_ctl_chk #(
    parameter int RST_CYCLES = 4
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_wr,
    input logic [31:0] csr_wdata,
    input logic        eng_err,
    input logic        mgr_stop,
    input logic [31:0] csr_rdata,
    input logic        fetch_ok
);
    logic [7:0]  st;
    logic        clr_wr;
    logic        act;
    logic [31:0] cyc_q;

    assign st     = csr_rdata[15:8];
    assign clr_wr = csr_wr && (csr_wdata[23:16] == 8'd9);
    assign act    = (st == 8'd1) || (st == 8'd2) || (st == 8'd3) || (st == 8'd4);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cyc_q <= '0;
        else if (st == 8'd9)  cyc_q <= cyc_q + 1;
        else                  cyc_q <= '0;
    end

    p_legal_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st <= 8'd5) || (st == 8'd9));

    p_fetch_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ok == ((st == 8'd1) || (st == 8'd2)));

    p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mgr_stop && !eng_err && !clr_wr && act && (st != 8'd4)) |=> (st == 8'd4));

    p_err_faults_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_err && act && !clr_wr) |=> (st == 8'd5));

    p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == 8'd5) && !clr_wr) |=> (st == 8'd5));

    p_clear_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 8'd9) |=> ((st == 8'd9) || (st == 8'd0)));

    p_clear_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 8'd9) |-> (cyc_q < RST_CYCLES));

    p_clear_echo_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == 8'd9) && csr_wr) |=> $stable(csr_rdata[23:16]));
endmodule

bind chan_ctl chan_ctl_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (csr_wr),
    .csr_wdata (csr_wdata),
    .eng_err   (eng_err),
    .mgr_stop  (mgr_stop),
    .csr_rdata (csr_rdata),
    .fetch_ok  (fetch_ok)
);

// File: tb/sim_chan_ctl.sv
`timescale 1ns/1ps
module sim_chan_ctl;
    localparam int QN = 4;
    localparam int NV = 18;

    typedef struct packed {
        logic       wr;
        logic [7:0] cmd;
        logic       pend;
        logic       err;
        logic       stop;
        logic [7:0] st;
        logic       fetch;
        logic [3:0] req;
    } vec_t;

    // wr cmd pend err stop | exp state fetch | requirement
    localparam vec_t VT [NV] = '{
        '{1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 4'd3},  // R3 enable off->idle
        '{1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 4'd3},  // R3 follows pending
        '{1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 4'd3},  // R3 back to idle
        '{1'b1, 8'd2, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0, 4'd4},  // R4 hold
        '{1'b0, 8'd0, 1'b1, 1'b0, 1'b0, 8'd3, 1'b0, 4'd5},  // R5 held, no fetch
        '{1'b1, 8'd2, 1'b0, 1'b0, 1'b0, 8'd3, 1'b0, 4'd4},  // R4 hold again no effect
        '{1'b1, 8'd1, 1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 4'd3},  // R3 resume to busy
        '{1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 8'd4, 1'b0, 4'd6},  // R6 stop
        '{1'b1, 8'd2, 1'b0, 1'b0, 1'b0, 8'd4, 1'b0, 4'd4},  // R4 hold in halted
        '{1'b1, 8'd1, 1'b0, 1'b0, 1'b0, 8'd1, 1'b1, 4'd3},  // R3 enable from halted
        '{1'b1, 8'd0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 4'd7},  // R7 off
        '{1'b0, 8'd0, 1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 4'd8},  // R8 R6 ignored in off
        '{1'b1, 8'd7, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 4'd2},  // R2 unknown code
        '{1'b1, 8'd1, 1'b1, 1'b0, 1'b0, 8'd2, 1'b1, 4'd3},  // R3 enable to busy
        '{1'b0, 8'd0, 1'b1, 1'b1, 1'b0, 8'd5, 1'b0, 4'd8},  // R8 error
        '{1'b1, 8'd1, 1'b1, 1'b0, 1'b0, 8'd5, 1'b0, 4'd9},  // R9 enable ignored
        '{1'b1, 8'd0, 1'b0, 1'b0, 1'b0, 8'd5, 1'b0, 4'd9},  // R9 off ignored
        '{1'b0, 8'd0, 1'b0, 1'b0, 1'b1, 8'd5, 1'b0, 4'd9}   // R9 stop ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        work_pend = 1'b0;
    logic        eng_err = 1'b0;
    logic        mgr_stop = 1'b0;
    logic [31:0] csr_rdata;
    logic        fetch_ok;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    chan_ctl #(.RST_CYCLES(QN)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .work_pend (work_pend),
        .eng_err   (eng_err),
        .mgr_stop  (mgr_stop),
        .csr_rdata (csr_rdata),
        .fetch_ok  (fetch_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [7:0] cmd, input logic pend,
                        input logic err, input logic stop);
        csr_wr    = wr;
        csr_wdata = {8'h00, cmd, 16'h0000};
        work_pend = pend;
        eng_err   = err;
        mgr_stop  = stop;
        @(posedge clk);
        #1;
        csr_wr   = 1'b0;
        eng_err  = 1'b0;
        mgr_stop = 1'b0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #200000;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset word", csr_rdata, 32'h0);
        check("R1 reset fetch", {31'd0, fetch_ok}, 32'd0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        for (int i = 0; i < NV; i++) begin
            step(VT[i].wr, VT[i].cmd, VT[i].pend, VT[i].err, VT[i].stop);
            check($sformatf("R%0d row%0d state", VT[i].req, i),
                  {24'd0, csr_rdata[15:8]}, {24'd0, VT[i].st});
            check($sformatf("R5 row%0d fetch", i), {31'd0, fetch_ok}, {31'd0, VT[i].fetch});
        end
        // R2 echo: last legal command was off (0) in fault, unknown 7 not echoed
        check("R2 word layout", csr_rdata, 32'h0000_0500);

        // R10 R12 clear beats error and stop in the same cycle
        step(1'b1, 8'd9, 1'b1, 1'b1, 1'b1);
        check("R12 clear first", csr_rdata, 32'h0009_0900);
        for (int k = 1; k < QN; k++) begin
            // R11 enable written, error and stop during clearing are ignored
            step(1'b1, 8'd1, 1'b1, 1'b1, 1'b1);
            check("R11 clearing holds", csr_rdata, 32'h0009_0900);
        end
        step(1'b1, 8'd1, 1'b1, 1'b0, 1'b0);
        check("R10 clear ends off", csr_rdata, 32'h0009_0000);

        // R12 error beats stop
        step(1'b1, 8'd1, 1'b0, 1'b0, 1'b0);
        check("R3 enable idle", csr_rdata[15:8], 32'd1);
        step(1'b0, 8'd0, 1'b0, 1'b1, 1'b1);
        check("R12 error over stop", csr_rdata[15:8], 32'd5);

        // clear out of fault, wait the quiesce out
        step(1'b1, 8'd9, 1'b0, 1'b0, 1'b0);
        for (int k = 1; k < QN; k++) step(1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
        check("R9 R10 fault cleared to off", csr_rdata[15:8], 32'd0);

        // R12 stop beats an off command
        step(1'b1, 8'd1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 8'd0, 1'b1, 1'b0, 1'b1);
        check("R12 stop over command", csr_rdata[15:8], 32'd4);
        // R8 error in halted
        step(1'b0, 8'd0, 1'b0, 1'b1, 1'b0);
        check("R8 error from halted", csr_rdata[15:8], 32'd5);

        // R6 stop in held goes halted; R7 off from halted
        step(1'b1, 8'd9, 1'b0, 1'b0, 1'b0);
        for (int k = 0; k < QN; k++) step(1'b0, 8'd0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'd1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 8'd2, 1'b0, 1'b0, 1'b0);
        step(1'b0, 8'd0, 1'b0, 1'b0, 1'b1);
        check("R6 stop from held", csr_rdata[15:8], 32'd4);
        step(1'b1, 8'd0, 1'b0, 1'b0, 1'b0);
        check("R7 off from halted", csr_rdata, 32'h0000_0000);

        finish_run();
    end
endmodule